// File: doc/BRIEF.md
# Priority Pending Interrupt Selector

This block looks at every interrupt line of a controller at once and picks the one that should be offered to the processor next. A line takes part only when it is both enabled and pending. Among those, the line with the numerically smallest priority value wins, because a smaller value means a more urgent interrupt. A balanced tree of two-input comparators makes the choice. At every node the lower-numbered side is kept unless the other side is strictly more urgent.

The winner then passes two filters. The first is a programmable priority mask, held in a small register that is loaded through a write strobe. The second is the priority of the interrupt the processor is already servicing. A winner that passes the mask is published as the highest-pending ID. The request line to the processor rises only when the winner would preempt the running interrupt. If nothing qualifies, or if the distributor or the CPU interface is switched off, the block publishes the reserved spurious ID 1023 and keeps the request low. Both outputs are registered.

Top module: `irq_prio_select`

## Requirements
- R1: The winner is the enabled and pending line whose priority value is numerically lowest.
- R2: When several qualifying lines share the lowest priority value, the one with the lowest line index wins.
- R3: If `dist_en_i` or `cpu_en_i` is low, or if no line has both its enable bit and its pending bit set, the next pend_id_o is 1023 and irq_o is 0.
- R4: If the winner's priority value is numerically greater than the mask, pend_id_o is 1023 and irq_o is 0. A priority equal to the mask passes.
- R5: If the winner passes the mask, pend_id_o carries its line index. irq_o is 1 only when the zero-extended winner priority is strictly lower than `run_prio_i`; an equal value leaves irq_o at 0.
- R6: The value 0x100 on `run_prio_i` means no interrupt is running. In that case any winner that passes the mask raises irq_o.
- R7: The mask register resets to 0xF0. A write through `mask_we_i` loads `mask_wdata_i` at a clock edge. The outputs first reflect the new mask in the cycle after that edge.
- R8: pend_id_o and irq_o are registered. They follow the inputs one clock later, and during reset they read 1023 and 0.
- R9: irq_o is never 1 while pend_id_o is 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_en_i | input | NUM_LINES | Per-line enable |
| line_pend_i | input | NUM_LINES | Per-line pending |
| line_prio_i | input | NUM_LINES*PRIO_W | Per-line priority; line k occupies bits [k*PRIO_W +: PRIO_W] |
| dist_en_i | input | 1 | Distributor enable |
| cpu_en_i | input | 1 | CPU interface enable |
| run_prio_i | input | PRIO_W+1 | Priority of the running interrupt; 0x100 when idle |
| mask_we_i | input | 1 | Load strobe for the mask register |
| mask_wdata_i | input | PRIO_W | New mask value |
| pend_id_o | output | 10 | Highest pending ID, or 1023 |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Two things can happen at the same clock edge: a load of the mask register, and a change in the line vectors or the running priority. In that cycle the selection has to use the old mask, and the new threshold must apply only from the next cycle. The bench provokes this collision in directed steps, where the winner sits exactly on the old and new thresholds. It also provokes it often in random traffic, where mask writes are mixed into changes of the lines and of the running priority. Every clock the outputs are compared with a behavioural model that updates its own copy of the mask after it evaluates the cycle.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int unsigned ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [1:0] {
    SEL_OFF    = 2'd0,
    SEL_MASKED = 2'd1,
    SEL_PASS   = 2'd2
  } sel_state_e;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned PRIO_W = 8,
  parameter logic [PRIO_W-1:0] MASK_RST = 8'hF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PRIO_W-1:0] wdata_i,
  output logic [PRIO_W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= MASK_RST;
    else if (we_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree #(
  parameter int unsigned NUM_LINES = 96,
  parameter int unsigned PRIO_W    = 8,
  localparam int unsigned IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int unsigned LEAVES   = 1 << IDX_W
) (
  input  logic [NUM_LINES-1:0]        req_i,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
  output logic                        vld_o,
  output logic [PRIO_W-1:0]           prio_o,
  output logic [IDX_W-1:0]            idx_o
);
  // heap layout: node k has children 2k and 2k+1, leaves at LEAVES+i
  logic              nd_vld  [2*LEAVES];
  logic [PRIO_W-1:0] nd_prio [2*LEAVES];
  logic [IDX_W-1:0]  nd_idx  [2*LEAVES];

  assign nd_vld[0]  = 1'b0;
  assign nd_prio[0] = '0;
  assign nd_idx[0]  = '0;

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NUM_LINES) begin : g_real
      assign nd_vld[LEAVES+i]  = req_i[i];
      assign nd_prio[LEAVES+i] = prio_i[i*PRIO_W +: PRIO_W];
    end else begin : g_pad
      assign nd_vld[LEAVES+i]  = 1'b0;
      assign nd_prio[LEAVES+i] = '1;
    end
    assign nd_idx[LEAVES+i] = IDX_W'(i);
  end

  for (genvar k = 1; k < LEAVES; k++) begin : g_node
    logic take_r;
    // right side wins only on strictly lower value: ties go to the lower index
    assign take_r = nd_vld[2*k+1] &&
                    (!nd_vld[2*k] || (nd_prio[2*k+1] < nd_prio[2*k]));
    assign nd_vld[k]  = nd_vld[2*k] || nd_vld[2*k+1];
    assign nd_prio[k] = take_r ? nd_prio[2*k+1] : nd_prio[2*k];
    assign nd_idx[k]  = take_r ? nd_idx[2*k+1]  : nd_idx[2*k];
  end

  assign vld_o  = nd_vld[1];
  assign prio_o = nd_prio[1];
  assign idx_o  = nd_idx[1];
endmodule

// File: rtl/irq_gate_filter.sv
module irq_gate_filter
  import irq_sel_pkg::*;
#(
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned IDX_W  = 7
) (
  input  logic              dist_en_i,
  input  logic              cpu_en_i,
  input  logic              vld_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [PRIO_W-1:0] mask_i,
  input  logic [PRIO_W:0]   run_prio_i,
  output logic [ID_W-1:0]   id_o,
  output logic              irq_o
);
  sel_state_e state;

  always_comb begin
    if (!dist_en_i || !cpu_en_i || !vld_i) state = SEL_OFF;
    else if (prio_i > mask_i)              state = SEL_MASKED;
    else                                   state = SEL_PASS;
  end

  always_comb begin
    id_o  = SPURIOUS_ID;
    irq_o = 1'b0;
    if (state == SEL_PASS) begin
      id_o  = ID_W'(idx_i);
      irq_o = ({1'b0, prio_i} < run_prio_i);
    end
  end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_sel_pkg::*;
#(
  parameter int unsigned NUM_LINES = 96,
  parameter int unsigned PRIO_W    = 8,
  parameter logic [PRIO_W-1:0] MASK_RST = 8'hF0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_LINES-1:0]        line_en_i,
  input  logic [NUM_LINES-1:0]        line_pend_i,
  input  logic [NUM_LINES*PRIO_W-1:0] line_prio_i,
  input  logic                        dist_en_i,
  input  logic                        cpu_en_i,
  input  logic [PRIO_W:0]             run_prio_i,
  input  logic                        mask_we_i,
  input  logic [PRIO_W-1:0]           mask_wdata_i,
  output logic [9:0]                  pend_id_o,
  output logic                        irq_o
);
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [PRIO_W-1:0] mask_q;
  logic              best_vld;
  logic [PRIO_W-1:0] best_prio;
  logic [IDX_W-1:0]  best_idx;
  logic [ID_W-1:0]   id_d;
  logic              irq_d;

  irq_mask_reg #(.PRIO_W(PRIO_W), .MASK_RST(MASK_RST)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we_i),
    .wdata_i (mask_wdata_i),
    .mask_o  (mask_q)
  );

  irq_prio_tree #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_tree (
    .req_i  (line_en_i & line_pend_i),
    .prio_i (line_prio_i),
    .vld_o  (best_vld),
    .prio_o (best_prio),
    .idx_o  (best_idx)
  );

  irq_gate_filter #(.PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_gate (
    .dist_en_i  (dist_en_i),
    .cpu_en_i   (cpu_en_i),
    .vld_i      (best_vld),
    .prio_i     (best_prio),
    .idx_i      (best_idx),
    .mask_i     (mask_q),
    .run_prio_i (run_prio_i),
    .id_o       (id_d),
    .irq_o      (irq_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_id_o <= SPURIOUS_ID;
      irq_o     <= 1'b0;
    end else begin
      pend_id_o <= id_d;
      irq_o     <= irq_d;
    end
  end
endmodule

// File: rtl/irq_prio_select_chk.sv
module irq_prio_select_chk #(
  parameter int unsigned NUM_LINES = 96,
  parameter int unsigned PRIO_W    = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NUM_LINES-1:0]        line_en_i,
  input logic [NUM_LINES-1:0]        line_pend_i,
  input logic [NUM_LINES*PRIO_W-1:0] line_prio_i,
  input logic                        dist_en_i,
  input logic                        cpu_en_i,
  input logic [PRIO_W:0]             run_prio_i,
  input logic [9:0]                  pend_id_o,
  input logic                        irq_o
);
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [NUM_LINES-1:0]        req_q;
  logic [NUM_LINES*PRIO_W-1:0] prio_q;
  logic [PRIO_W:0]             run_q;
  logic                        on_q;
  logic [IDX_W-1:0]            idx;
  logic [PRIO_W-1:0]           win_prio;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      prio_q <= '0;
      run_q  <= '0;
      on_q   <= 1'b0;
    end else begin
      req_q  <= line_en_i & line_pend_i;
      prio_q <= line_prio_i;
      run_q  <= run_prio_i;
      on_q   <= dist_en_i && cpu_en_i;
    end
  end

  assign idx      = pend_id_o[IDX_W-1:0];
  assign win_prio = prio_q[idx*PRIO_W +: PRIO_W];

  AST_IRQ_HAS_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_id_o != 10'd1023)); // R9
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on_q |-> (pend_id_o == 10'd1023 && !irq_o)); // R3
  AST_ID_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_id_o != 10'd1023) |-> (pend_id_o < NUM_LINES)); // R5
  AST_ID_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_id_o != 10'd1023) |-> req_q[idx]); // R5
  AST_IRQ_PREEMPTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ({1'b0, win_prio} < run_q)); // R5
endmodule

bind irq_prio_select irq_prio_select_chk #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_en_i   (line_en_i),
  .line_pend_i (line_pend_i),
  .line_prio_i (line_prio_i),
  .dist_en_i   (dist_en_i),
  .cpu_en_i    (cpu_en_i),
  .run_prio_i  (run_prio_i),
  .pend_id_o   (pend_id_o),
  .irq_o       (irq_o)
);

// File: tb/sim_irq_prio_select.sv
`timescale 1ns/1ps
module sim_irq_prio_select;
  localparam int N  = 96;
  localparam int PW = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N-1:0]    line_en_i = '0;
  logic [N-1:0]    line_pend_i = '0;
  logic [N*PW-1:0] line_prio_i = '0;
  logic            dist_en_i = 1'b0;
  logic            cpu_en_i = 1'b0;
  logic [PW:0]     run_prio_i = 9'h100;
  logic            mask_we_i = 1'b0;
  logic [PW-1:0]   mask_wdata_i = '0;
  logic [9:0]      pend_id_o;
  logic            irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int mask_m = 'hF0;

  always #2.5 clk_i = ~clk_i;

  irq_prio_select u0 (.*);

  function automatic int prio_of(int k);
    return int'(line_prio_i[k*PW +: PW]);
  endfunction

  // behavioural reference: linear scan, evaluated on the inputs before the edge
  task automatic model(output int id, output bit irq, output string tag);
    int best_p = 256;
    int best_k = -1;
    for (int k = 0; k < N; k++)
      if (line_en_i[k] && line_pend_i[k] && prio_of(k) < best_p) begin
        best_p = prio_of(k);
        best_k = k;
      end
    id = 1023; irq = 1'b0;
    if (!dist_en_i || !cpu_en_i || best_k < 0) tag = "R3";
    else if (best_p > mask_m) tag = "R4";
    else begin
      id  = best_k;
      irq = (best_p < int'(run_prio_i));
      tag = (run_prio_i == 9'h100) ? "R6" : "R5";
    end
  endtask

  task automatic check(int id_e, bit irq_e, string tag);
    checks++;
    if (pend_id_o != 10'(id_e) || irq_o != irq_e) begin
      fails++;
      $display("FAIL %s: id=%0d irq=%0d expected id=%0d irq=%0d",
               tag, pend_id_o, irq_o, id_e, irq_e);
    end
  endtask

  // called at a negedge with inputs set; checks the outputs one edge later
  task automatic step(int id_c, bit irq_c, string tag);
    int id_e; bit irq_e; string mt;
    model(id_e, irq_e, mt);
    if (mask_we_i) mask_m = int'(mask_wdata_i);
    @(posedge clk_i); @(negedge clk_i);
    if (id_c >= -1) check(id_c < 0 ? 1023 : id_c, irq_c, tag);
    check(id_e, irq_e, mt);
    checks++;
    if (irq_o && pend_id_o == 10'd1023) begin
      fails++;
      $display("FAIL R9: id=%0d irq=%0d expected id!=1023", pend_id_o, irq_o);
    end
    mask_we_i = 1'b0;
  endtask

  task automatic set_line(int k, bit en, bit pend, int p);
    line_en_i[k] = en; line_pend_i[k] = pend; line_prio_i[k*PW +: PW] = PW'(p);
  endtask

  task automatic clear_lines();
    line_en_i = '0; line_pend_i = '0; line_prio_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(1023, 1'b0, "R8 reset");
    rst_ni = 1'b1;
    dist_en_i = 1'b1; cpu_en_i = 1'b1; run_prio_i = 9'h100;
    set_line(5, 1, 1, 'hF0);
    step(5, 1'b1, "R7 mask reset passes 0xF0");
    set_line(5, 1, 1, 'hF1);
    step(-1, 1'b0, "R4 above mask");
    clear_lines();
    set_line(3, 1, 1, 20); set_line(40, 1, 1, 7);
    step(40, 1'b1, "R1 lowest value");
    clear_lines();
    set_line(10, 1, 1, 9); set_line(60, 1, 1, 9);
    step(10, 1'b1, "R2 tie");
    run_prio_i = 9'd9;
    step(10, 1'b0, "R5 equal running");
    run_prio_i = 9'd10;
    step(10, 1'b1, "R5 below running");
    dist_en_i = 1'b0;
    step(-1, 1'b0, "R3 dist off");
    dist_en_i = 1'b1; cpu_en_i = 1'b0;
    step(-1, 1'b0, "R3 cpu off");
    cpu_en_i = 1'b1; line_en_i = '0;
    step(-1, 1'b0, "R3 not enabled");
    line_en_i[10] = 1'b1;
    mask_we_i = 1'b1; mask_wdata_i = 8'd8;
    step(10, 1'b1, "R7 old mask in load cycle");
    step(-1, 1'b0, "R7 new mask");
    mask_we_i = 1'b1; mask_wdata_i = 8'd9;
    step(-1, 1'b0, "R7 load cycle");
    run_prio_i = 9'h100;
    step(10, 1'b1, "R6 idle running");
    for (int c = 0; c < 4000; c++) begin
      for (int k = 0; k < N; k++) begin
        line_en_i[k]   = ($urandom % 8) != 0;
        line_pend_i[k] = ($urandom % 24) == 0;
        line_prio_i[k*PW +: PW] = (c % 3 == 0) ? PW'($urandom) : PW'($urandom % 8 + 4);
      end
      dist_en_i  = ($urandom % 10) != 0;
      cpu_en_i   = ($urandom % 10) != 0;
      run_prio_i = ($urandom % 4 == 0) ? 9'h100 : 9'($urandom % 16);
      if ($urandom % 6 == 0) begin
        mask_we_i = 1'b1;
        mask_wdata_i = ($urandom % 2) ? PW'($urandom % 16) : PW'($urandom);
      end
      step(-2, 1'b0, "random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule